// File: doc/BRIEF.md
# Segmented Run-of-Ones Zone Detector

This block takes a long sample frame one bit at a time and decides, for each of several equal zones of that frame, whether the zone holds a long enough run of consecutive ones. A start-of-frame pulse arms the block. Every bit that follows with its valid strobe high is placed at the next position of the frame. The frame is split into `ZONES` consecutive zones of `ZONE_BITS` bits each (24 zones of 85 bits, 2040 bits in all, by default). A zone is flagged when it holds a run of at least `MIN_RUN` ones (5 by default). Each flag is meant to fire one actuator channel.

The run length is counted separately in each zone, so a run that crosses a zone boundary is counted in two parts. When the last bit of the frame arrives, the block copies the flag vector into an output register that holds its value until the next frame completes. In the same cycle it raises a one-cycle done pulse. A new start pulse that arrives in the middle of a frame drops the partial frame without a done pulse.

Top module: `zone_run_flagger`

## Requirements
- R1: While reset is high and after it is released, `zoneFlags` is all zeros and `frameDone` is low until the first frame completes.
- R2: A zone that holds exactly `MIN_RUN` consecutive accepted ones sets its flag.
- R3: A run longer than `MIN_RUN` also sets the flag of its zone. The count saturates, so runs of any length behave the same.
- R4: A frame that is all zeros, or that holds only runs shorter than `MIN_RUN` (isolated ones, pairs, triples, alternating 1010 patterns), sets no flag.
- R5: The run count restarts at every zone boundary. A run split across two zones is counted in each zone on its own. A run of `MIN_RUN` that ends on a zone's last bit flags that zone.
- R6: The first accepted bit after a start pulse is bit 0 of zone 0. Zone k covers frame bits k*`ZONE_BITS` to (k+1)*`ZONE_BITS`-1, and its result appears on bit k of `zoneFlags`.
- R7: The clock edge that accepts the last bit of the frame updates `zoneFlags` and raises `frameDone` for exactly one cycle. `zoneFlags` does not change at any other time.
- R8: A cycle with `bitValid` low does not advance the frame position and does not break a run, whatever `bitData` carries.
- R9: A start pulse in the middle of a frame drops that frame. No done pulse is given for it, and no zone hit from it carries into the next frame.
- R10: Valid bits that arrive while the block is not armed are ignored and cause no done pulse. The block is not armed after reset or after a frame completes, and it is armed again by a start pulse.
- R11: A valid bit that arrives in the same cycle as the start pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sofIn | input | 1 | Start-of-frame pulse; clears the frame state and arms the block |
| bitValid | input | 1 | Qualifies `bitData` this cycle |
| bitData | input | 1 | Serial sample bit |
| zoneFlags | output | ZONES | Registered per-zone flags of the last completed frame |
| frameDone | output | 1 | One-cycle pulse when `zoneFlags` is updated |

## Verification
The bench targets runs that sit exactly on the threshold, runs that sit on the edge of a zone, and runs split across a boundary. A design with an off-by-one in the count would miss the 5-run or would flag the 4-run. A design that does not restart the count at each zone would flag a 3+3 run that crosses a boundary. A misplaced zone index would light the wrong flag bit. Other cases are idle gaps inside a run, a bit sent together with the start pulse, an aborted frame, and bits that arrive while the block is not armed. A design that treats gaps as zeros would lose the gapped run. One that counts the start-cycle bit would shift the whole frame. One that keeps its hits through an abort, or that accepts bits while not armed, would give false flags or an extra done pulse.

// File: rtl/zrf_pkg.sv
package zrf_pkg;
  // strobes from the control path to the datapath
  typedef struct packed {
    logic clearAll;   // start of frame: wipe live state
    logic advance;    // an accepted frame bit this cycle
    logic zoneFirst;  // the accepted bit is bit 0 of its zone
    logic lastBit;    // the accepted bit is the last bit of the frame
  } ctrl_t;
endpackage

// File: rtl/zrf_control.sv
module zrf_control #(
  parameter int ZONES     = 24,
  parameter int ZONE_BITS = 85,
  parameter int POS_W     = 7,
  parameter int ZONE_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sofIn,
  input  logic                bitValid,
  output zrf_pkg::ctrl_t      ctrl,
  output logic [ZONE_W-1:0]   zoneIdx
);
  localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(ZONE_BITS - 1);
  localparam logic [ZONE_W-1:0] ZONE_LAST = ZONE_W'(ZONES - 1);

  logic [POS_W-1:0] bitPos;
  logic             armed;
  logic             zoneEnd;

  assign zoneEnd        = (bitPos == POS_LAST);
  assign ctrl.clearAll  = sofIn;
  assign ctrl.advance   = armed && bitValid && !sofIn;
  assign ctrl.zoneFirst = (bitPos == '0);
  assign ctrl.lastBit   = ctrl.advance && zoneEnd && (zoneIdx == ZONE_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      bitPos  <= '0;
      zoneIdx <= '0;
    end else if (sofIn) begin
      armed   <= 1'b1;
      bitPos  <= '0;
      zoneIdx <= '0;
    end else if (ctrl.advance) begin
      if (zoneEnd) begin
        bitPos <= '0;
        if (zoneIdx == ZONE_LAST) begin
          zoneIdx <= '0;
          armed   <= 1'b0;
        end else begin
          zoneIdx <= zoneIdx + 1'b1;
        end
      end else begin
        bitPos <= bitPos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/zrf_datapath.sv
module zrf_datapath #(
  parameter int ZONES   = 24,
  parameter int MIN_RUN = 5,
  parameter int ZONE_W  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  zrf_pkg::ctrl_t     ctrl,
  input  logic [ZONE_W-1:0]  zoneIdx,
  input  logic               bitData,
  output logic [ZONES-1:0]   zoneFlags,
  output logic               frameDone
);
  localparam int             RUN_W   = $clog2(MIN_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(MIN_RUN);

  logic [RUN_W-1:0] runLen, runBase, runNext;
  logic             runHit;
  logic [ZONES-1:0] liveFlags, hitSel;

  // saturating run length, restarted on the first bit of each zone
  always_comb begin
    runBase = ctrl.zoneFirst ? '0 : runLen;
    if (!bitData)              runNext = '0;
    else if (runBase == RUN_TOP) runNext = runBase;
    else                       runNext = runBase + 1'b1;
  end
  assign runHit = ctrl.advance && (runNext == RUN_TOP);

  always_ff @(posedge clk) begin
    if (rst || ctrl.clearAll) runLen <= '0;
    else if (ctrl.advance)    runLen <= runNext;
  end

  for (genvar z = 0; z < ZONES; z++) begin : g_zone
    assign hitSel[z] = runHit && (zoneIdx == ZONE_W'(z));
    always_ff @(posedge clk) begin
      if (rst || ctrl.clearAll) liveFlags[z] <= 1'b0;
      else if (hitSel[z])       liveFlags[z] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zoneFlags <= '0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= ctrl.lastBit;
      if (ctrl.lastBit) zoneFlags <= liveFlags | hitSel;
    end
  end
endmodule

// File: rtl/zone_run_flagger.sv
module zone_run_flagger #(
  parameter int ZONES     = 24,
  parameter int ZONE_BITS = 85,
  parameter int MIN_RUN   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sofIn,
  input  logic             bitValid,
  input  logic             bitData,
  output logic [ZONES-1:0] zoneFlags,
  output logic             frameDone
);
  localparam int POS_W  = (ZONE_BITS > 1) ? $clog2(ZONE_BITS) : 1;
  localparam int ZONE_W = (ZONES > 1) ? $clog2(ZONES) : 1;

  zrf_pkg::ctrl_t    ctrl;
  logic [ZONE_W-1:0] zoneIdx;

  zrf_control #(
    .ZONES(ZONES), .ZONE_BITS(ZONE_BITS), .POS_W(POS_W), .ZONE_W(ZONE_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .sofIn(sofIn), .bitValid(bitValid),
    .ctrl(ctrl), .zoneIdx(zoneIdx)
  );

  zrf_datapath #(
    .ZONES(ZONES), .MIN_RUN(MIN_RUN), .ZONE_W(ZONE_W)
  ) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .zoneIdx(zoneIdx), .bitData(bitData),
    .zoneFlags(zoneFlags), .frameDone(frameDone)
  );
endmodule

// File: rtl/zrf_checker.sv
module zrf_checker #(
  parameter int ZONES  = 24,
  parameter int ZONE_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              sofIn,
  input logic              advance,
  input logic              lastBit,
  input logic [ZONE_W-1:0] zoneIdx,
  input logic [ZONES-1:0]  zoneFlags,
  input logic              frameDone
);
  // R7: the done pulse lasts one cycle
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    frameDone |=> !frameDone);

  // R7: flags only move together with a done pulse
  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !frameDone |-> $stable(zoneFlags));

  // R7: the last accepted bit is followed by a done pulse
  assert_last_to_done_R7: assert property (@(posedge clk) disable iff (rst)
    lastBit |=> frameDone);

  // R9: a start pulse is never followed by a done pulse
  assert_abort_no_done_R9: assert property (@(posedge clk) disable iff (rst)
    sofIn |=> !frameDone);

  // R11: no bit is taken in a start cycle
  assert_sof_bit_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    sofIn |-> !advance);

  // R6: the zone index stays inside the frame
  assert_zone_range_R6: assert property (@(posedge clk) disable iff (rst)
    int'(zoneIdx) < ZONES);
endmodule

bind zone_run_flagger zrf_checker #(.ZONES(ZONES), .ZONE_W(ZONE_W)) u_chk (
  .clk(clk), .rst(rst), .sofIn(sofIn), .advance(ctrl.advance),
  .lastBit(ctrl.lastBit), .zoneIdx(zoneIdx), .zoneFlags(zoneFlags),
  .frameDone(frameDone)
);

// File: tb/tb_zone_run_flagger.sv
module tb_zone_run_flagger;
  localparam int CLK_PERIOD = 10;
  localparam int ZONES = 24, ZB = 85, MINR = 5;
  localparam int NBITS = ZONES * ZB;

  logic clk = 0, rst = 1, sofIn = 0, bitValid = 0, bitData = 0;
  logic [ZONES-1:0] zoneFlags;
  logic frameDone;

  zone_run_flagger #(.ZONES(ZONES), .ZONE_BITS(ZB), .MIN_RUN(MINR)) dut (
    .clk(clk), .rst(rst), .sofIn(sofIn), .bitValid(bitValid),
    .bitData(bitData), .zoneFlags(zoneFlags), .frameDone(frameDone));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nFails = 0, cycles = 0;
  bit frm [NBITS];
  int earlyDone;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected < 150000)", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearFrame();
    for (int i = 0; i < NBITS; i++) frm[i] = 0;
  endtask

  task automatic putRun(input int start, input int len);
    for (int i = start; i < start + len; i++) frm[i] = 1;
  endtask

  // expected flags: per-zone run length, restarted at each zone boundary
  function automatic logic [ZONES-1:0] model();
    logic [ZONES-1:0] f = '0;
    for (int z = 0; z < ZONES; z++) begin
      int run = 0;
      for (int b = 0; b < ZB; b++) begin
        run = frm[z*ZB + b] ? run + 1 : 0;
        if (run >= MINR) f[z] = 1'b1;
      end
    end
    return f;
  endfunction

  // start pulse (optionally carrying a valid one bit), then stopAt bits, with optional gaps
  task automatic playFrame(input bit sofBit, input int gapMod, input int stopAt);
    @(negedge clk);
    sofIn = 1; bitValid = sofBit; bitData = sofBit;
    earlyDone = 0;
    for (int i = 0; i < stopAt; i++) begin
      if (gapMod > 0 && (i % gapMod) == 1) begin
        @(negedge clk);
        if (frameDone) earlyDone++;
        sofIn = 0; bitValid = 0; bitData = 0;
      end
      @(negedge clk);
      if (frameDone) earlyDone++;
      sofIn = 0; bitValid = 1; bitData = frm[i];
    end
    @(negedge clk);
    sofIn = 0; bitValid = 0; bitData = 0;
  endtask

  task automatic finishCheck(input string req);
    logic [ZONES-1:0] exp = model();
    check(earlyDone == 0, {req, " no early done"}, earlyDone, 0);
    check(frameDone === 1'b1, {req, "/R7 done at last bit"}, frameDone, 1);
    check(zoneFlags === exp, req, zoneFlags, exp);
    @(negedge clk);
    check(frameDone === 1'b0, "R7 done one cycle", frameDone, 0);
    check(zoneFlags === exp, "R7 flags held", zoneFlags, exp);
  endtask

  task automatic testReset();
    check(zoneFlags === '0 && frameDone === 1'b0, "R1 in reset", {zoneFlags, frameDone}, 0);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check(zoneFlags === '0 && frameDone === 1'b0, "R1 after reset", {zoneFlags, frameDone}, 0);
  endtask

  task automatic testUnarmed();
    int seen = 0;
    for (int i = 0; i < NBITS + 60; i++) begin
      @(negedge clk);
      if (frameDone) seen++;
      bitValid = 1; bitData = 1;
    end
    @(negedge clk); if (frameDone) seen++;
    bitValid = 0; bitData = 0;
    @(negedge clk); if (frameDone) seen++;
    check(seen == 0, "R10 unarmed bits ignored", seen, 0);
    check(zoneFlags === '0, "R10 flags untouched", zoneFlags, 0);
  endtask

  task automatic testZeros();
    clearFrame();
    playFrame(0, 0, NBITS);
    finishCheck("R4 all zero");
  endtask

  task automatic testExact();
    clearFrame();
    putRun(0, 5);            // zone 0 bits 0..4
    putRun(3*ZB + 40, 5);    // zone 3 middle
    putRun(9*ZB + 10, 4);    // zone 9 only four: no flag
    playFrame(0, 0, NBITS);
    finishCheck("R2/R6 exact run");
    check(zoneFlags[0] && zoneFlags[3] && !zoneFlags[9], "R6 zone bit map", zoneFlags, 24'h9);
  endtask

  task automatic testLongAndEdge();
    clearFrame();
    putRun(10*ZB + 20, 40);  // long run zone 10
    putRun(17*ZB, ZB);       // whole zone 17
    putRun(23*ZB + ZB-5, 5); // ends on last frame bit
    putRun(6*ZB - 5, 5);     // ends on last bit of zone 5
    playFrame(0, 0, NBITS);
    finishCheck("R3/R5 long and edge runs");
  endtask

  task automatic testShort();
    clearFrame();
    for (int i = 0; i < ZB; i += 2) frm[i] = 1;       // 1010 in zone 0
    for (int z = 1; z < 4; z++)
      for (int i = 0; i + 4 < ZB; i += 5) putRun(z*ZB + i, z); // ones, pairs, triples
    putRun(6*ZB - 3, 6);      // 3+3 across zones 5/6
    putRun(12*ZB - 4, 8);     // 4+4 across zones 11/12
    putRun(20*ZB - 4, 9);     // 4+5 across 19/20: only zone 20
    playFrame(0, 0, NBITS);
    finishCheck("R4/R5 short and split runs");
  endtask

  task automatic testGaps();
    clearFrame();
    putRun(7*ZB + 30, 5);
    playFrame(0, 3, NBITS);
    finishCheck("R8 idle gaps");
  endtask

  task automatic testSofBit();
    clearFrame();
    putRun(0, 4);             // with the start-cycle bit counted it would be 5
    playFrame(1, 0, NBITS);
    finishCheck("R11 start-cycle bit");
  endtask

  task automatic testAbort();
    logic [ZONES-1:0] held;
    clearFrame();
    putRun(ZB + 5, 10);
    playFrame(0, 0, NBITS);
    finishCheck("R9 setup frame");
    held = zoneFlags;
    putRun(2*ZB + 5, 10);     // zone 2 hit in the frame to abort
    playFrame(0, 0, 1000);
    check(earlyDone == 0 && frameDone === 1'b0, "R9 no done on partial", earlyDone, 0);
    check(zoneFlags === held, "R9/R7 output held on abort", zoneFlags, held);
    clearFrame();
    playFrame(0, 0, NBITS);
    finishCheck("R9 abort leaves no hits");
  endtask

  initial begin
    rst = 1;
    repeat (3) @(negedge clk);
    testReset();
    testUnarmed();
    testZeros();
    testExact();
    testLongAndEdge();
    testShort();
    testGaps();
    testSofBit();
    testAbort();
    testUnarmed();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule